// File: doc/BRIEF.md
# Two-Digit Multiplexed Decimal Counter Display

This block counts from 0 up to 19 at a slow, human-visible rate and shows the value on two digits of a common-anode seven-segment display. Both digits share a single set of segment lines. The block therefore drives one digit at a time and switches between the two at a refresh rate far above the count rate, so both digits look steadily lit. The only inputs are a clock and a synchronous reset. The outputs are seven active-low segment lines and four active-low anode enables.

Inside, a control module holds two free-running dividers. The slow divider gives a one-cycle count strobe. The fast divider flips the digit select. The datapath module holds a BCD tens/units counter, the digit-to-segment decoder and one output register stage. That stage loads the anodes and the segments together. The tens digit is blanked while it is zero, so values 0 to 9 light only the units digit. The count interval (`TICK_DIV` cycles), the refresh interval (`REFRESH_DIV` cycles) and the terminal count (`MAX_COUNT`) are parameters.

Top module: `twoDigitDisplay`

## Requirements
- R1: In the clock cycle after any clock edge that samples `rst` high, `anode` is 4'b1111 and `seg` is 7'b1111111.
- R2: `seg[6:0]` is active low, with bit 6 the top segment and bit 0 the middle segment. Digit codes: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100. The blank pattern is 1111111.
- R3: Once out of reset, `anode` is 4'b1110 while the units digit is shown and 4'b1101 while the tens digit is shown. `anode[3:2]` is always 2'b11.
- R4: Number clock edges from reset release, with the first edge that samples `rst` low as e=1. After edge e (e>=1), the displayed value is floor((e-1)/TICK_DIV) mod (MAX_COUNT+1).
- R5: After the terminal count `MAX_COUNT` (19), the next count step returns both digits to 0.
- R6: While the value is below 10, the tens slot (anode 4'b1101) shows the blank pattern.
- R7: After edge e (e>=1), the units digit is selected when floor((e-1)/REFRESH_DIV) is even and the tens digit when it is odd. Neither anode is ever held for more than `REFRESH_DIV` cycles in a row.
- R8: The segments and the anode select change in the same cycle. The pattern on `seg` always belongs to the digit whose anode is low in that cycle. After reset release, `anode` never returns to 4'b1111.
- R9: The units digit always shows one of the ten digit codes and is never blank. The tens digit shows only blank or a code in 1..MAX_COUNT/10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg | output | 7 | Segment lines, active low, bit 6 = top segment |
| anode | output | 4 | Digit enables, active low; bit 0 = units, bit 1 = tens |

## Verification
The assertions assume a single clock and a clean synchronous reset. They also assume that the refresh interval is shorter than the count interval, so every value is seen on both digits before it changes. The bench keeps within this by choosing a 4-cycle refresh against a 40-cycle count step. It changes reset only on the falling clock edge, including one reset applied in the middle of a run. Expected outputs come from an edge counter in the bench that restarts whenever reset is sampled, so the bench and the design agree on the time origin after every reset.

// File: rtl/dispPkg.sv
package dispPkg;

  localparam int ANODE_COUNT = 4;
  localparam int SEG_COUNT   = 7;

  localparam logic [SEG_COUNT-1:0]   SEG_BLANK  = 7'b1111111;
  localparam logic [ANODE_COUNT-1:0] ANODE_IDLE = 4'b1111;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic countTick;  // one-cycle count advance
    logic digitSel;   // 0 = units, 1 = tens
  } dispStrobe_t;

  // Active-low segment pattern for one BCD digit, bit 6 = top segment
  function automatic logic [SEG_COUNT-1:0] segOf(input logic [3:0] digit);
    logic [SEG_COUNT-1:0] pat;
    case (digit)
      4'd0:    pat = 7'b0000001;
      4'd1:    pat = 7'b1001111;
      4'd2:    pat = 7'b0010010;
      4'd3:    pat = 7'b0000110;
      4'd4:    pat = 7'b1001100;
      4'd5:    pat = 7'b0100100;
      4'd6:    pat = 7'b0100000;
      4'd7:    pat = 7'b0001111;
      4'd8:    pat = 7'b0000000;
      4'd9:    pat = 7'b0000100;
      default: pat = SEG_BLANK;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/dispCtrl.sv
module dispCtrl
  import dispPkg::*;
#(
  parameter int TICK_DIV    = 25_000_000,
  parameter int REFRESH_DIV = 100_000
) (
  input  logic        clk,
  input  logic        rst,
  output dispStrobe_t strobes
);

  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int REF_W  = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);
  localparam logic [REF_W-1:0]  REF_LAST  = REF_W'(REFRESH_DIV - 1);

  logic [TICK_W-1:0] tickCnt;
  logic [REF_W-1:0]  refCnt;
  logic              tickLast;
  logic              refLast;
  logic              digitSel;

  assign tickLast = (tickCnt == TICK_LAST);
  assign refLast  = (refCnt == REF_LAST);

  // slow divider: count strobe once per TICK_DIV cycles
  always_ff @(posedge clk) begin
    if (rst)           tickCnt <= '0;
    else if (tickLast) tickCnt <= '0;
    else               tickCnt <= tickCnt + 1'b1;
  end

  // fast divider: digit select flips once per REFRESH_DIV cycles
  always_ff @(posedge clk) begin
    if (rst)          refCnt <= '0;
    else if (refLast) refCnt <= '0;
    else              refCnt <= refCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          digitSel <= 1'b0;
    else if (refLast) digitSel <= ~digitSel;
  end

  always_comb begin
    strobes.countTick = tickLast;
    strobes.digitSel  = digitSel;
  end

endmodule

// File: rtl/dispData.sv
module dispData
  import dispPkg::*;
#(
  parameter int MAX_COUNT   = 19,
  parameter bit BLANK_LEAD0 = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dispStrobe_t            strobes,
  output logic [SEG_COUNT-1:0]   seg,
  output logic [ANODE_COUNT-1:0] anode
);

  localparam logic [3:0] TENS_TOP  = 4'(MAX_COUNT / 10);
  localparam logic [3:0] UNITS_TOP = 4'(MAX_COUNT % 10);

  logic [3:0] unitsDigit;
  logic [3:0] tensDigit;
  logic       atTerminal;
  logic       unitsRoll;
  logic [3:0] shownDigit;
  logic       blankShown;
  logic [SEG_COUNT-1:0]   segNext;
  logic [ANODE_COUNT-1:0] anodeNext;

  assign atTerminal = (tensDigit == TENS_TOP) && (unitsDigit == UNITS_TOP);
  assign unitsRoll  = (unitsDigit == 4'd9);

  // BCD counter with wrap after the terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      unitsDigit <= '0;
      tensDigit  <= '0;
    end else if (strobes.countTick) begin
      if (atTerminal) begin
        unitsDigit <= '0;
        tensDigit  <= '0;
      end else if (unitsRoll) begin
        unitsDigit <= '0;
        tensDigit  <= tensDigit + 1'b1;
      end else begin
        unitsDigit <= unitsDigit + 1'b1;
      end
    end
  end

  // digit mux, leading-zero blanking, decode
  generate
    if (BLANK_LEAD0) begin : g_blank
      assign blankShown = strobes.digitSel && (tensDigit == 4'd0);
    end else begin : g_noBlank
      assign blankShown = 1'b0;
    end
  endgenerate

  assign shownDigit = strobes.digitSel ? tensDigit : unitsDigit;

  always_comb begin
    segNext   = blankShown ? SEG_BLANK : segOf(shownDigit);
    anodeNext = ANODE_IDLE;
    if (strobes.digitSel) anodeNext[1] = 1'b0;
    else                  anodeNext[0] = 1'b0;
  end

  // one register stage loads anode and segments together
  always_ff @(posedge clk) begin
    if (rst) begin
      seg   <= SEG_BLANK;
      anode <= ANODE_IDLE;
    end else begin
      seg   <= segNext;
      anode <= anodeNext;
    end
  end

endmodule

// File: rtl/twoDigitDisplay.sv
module twoDigitDisplay #(
  parameter int TICK_DIV    = 25_000_000,
  parameter int REFRESH_DIV = 100_000,
  parameter int MAX_COUNT   = 19
) (
  input  logic       clk,
  input  logic       rst,
  output logic [6:0] seg,
  output logic [3:0] anode
);

  dispPkg::dispStrobe_t strobes;

  dispCtrl #(
    .TICK_DIV   (TICK_DIV),
    .REFRESH_DIV(REFRESH_DIV)
  ) ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  dispData #(
    .MAX_COUNT  (MAX_COUNT),
    .BLANK_LEAD0(1'b1)
  ) data (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .seg    (seg),
    .anode  (anode)
  );

endmodule

// File: rtl/twoDigitDisplay_chk.sv
module twoDigitDisplay_chk #(
  parameter int REFRESH_DIV = 100_000,
  parameter int MAX_COUNT   = 19
) (
  input logic       clk,
  input logic       rst,
  input logic [6:0] seg,
  input logic [3:0] anode
);

  localparam int RUN_W = $clog2(REFRESH_DIV + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [3:0]       prevAnode;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevAnode <= 4'b1111;
      runLen    <= '0;
    end else begin
      prevAnode <= anode;
      if (anode != prevAnode) runLen <= 1;
      else if (runLen != RUN_MAX) runLen <= runLen + 1'b1;
    end
  end

  function automatic bit unitsValid(input logic [6:0] s);
    bit ok = 1'b0;
    for (int i = 0; i < 10; i++) if (s == dispPkg::segOf(4'(i))) ok = 1'b1;
    return ok;
  endfunction

  function automatic bit tensValid(input logic [6:0] s);
    bit ok = (s == dispPkg::SEG_BLANK);
    for (int i = 1; i <= MAX_COUNT / 10; i++) if (s == dispPkg::segOf(4'(i))) ok = 1'b1;
    return ok;
  endfunction

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (anode == 4'b1111 && seg == 7'b1111111));

  // R3
  anode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (anode[3:2] == 2'b11) && (anode[1:0] != 2'b00));

  // R8
  no_idle_return_chk: assert property (@(posedge clk) disable iff (rst)
    (anode != 4'b1111) |=> (anode != 4'b1111));

  // R9
  units_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (anode == 4'b1110) |-> unitsValid(seg));

  // R6
  tens_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (anode == 4'b1101) |-> tensValid(seg));

  // R7
  refresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    runLen <= RUN_W'(REFRESH_DIV));

endmodule

bind twoDigitDisplay twoDigitDisplay_chk #(
  .REFRESH_DIV(REFRESH_DIV),
  .MAX_COUNT  (MAX_COUNT)
) chk (
  .clk  (clk),
  .rst  (rst),
  .seg  (seg),
  .anode(anode)
);

// File: tb/twoDigitDisplay_test.sv
`timescale 1ns/1ps
module twoDigitDisplay_test;

  localparam int TICK  = 40;
  localparam int REF   = 4;
  localparam int MAXC  = 19;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] seg;
  logic [3:0] anode;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;
  bit done   = 1'b0;

  twoDigitDisplay #(
    .TICK_DIV   (TICK),
    .REFRESH_DIV(REF),
    .MAX_COUNT  (MAXC)
  ) uut (
    .clk  (clk),
    .rst  (rst),
    .seg  (seg),
    .anode(anode)
  );

  always #2.5 clk = ~clk;

  // edges since reset release, restarted by every sampled reset
  always @(posedge clk) edgeNo <= rst ? 0 : edgeNo + 1;

  // R2 code table
  function automatic logic [6:0] pattern(input int d);
    case (d)
      0: return 7'b0000001;
      1: return 7'b1001111;
      2: return 7'b0010010;
      3: return 7'b0000110;
      4: return 7'b1001100;
      5: return 7'b0100100;
      6: return 7'b0100000;
      7: return 7'b0001111;
      8: return 7'b0000000;
      9: return 7'b0000100;
      default: return 7'b1111111;
    endcase
  endfunction

  function automatic int expValue(input int e);
    return ((e - 1) / TICK) % (MAXC + 1);
  endfunction

  function automatic bit expTens(input int e);
    return ((e - 1) / REF) % 2 == 1;
  endfunction

  function automatic logic [3:0] expAnode(input int e);
    if (e == 0) return 4'b1111;
    return expTens(e) ? 4'b1101 : 4'b1110;
  endfunction

  function automatic logic [6:0] expSeg(input int e);
    int v;
    if (e == 0) return 7'b1111111;
    v = expValue(e);
    if (expTens(e)) return (v < 10) ? 7'b1111111 : pattern(v / 10);
    return pattern(v % 10);
  endfunction

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual=%b expected=%b", tag, what, edgeNo, act, exp);
    end
  endtask

  // sample the outputs against the model
  task automatic checkNow(input string tag);
    checkEq(tag, "anode", int'(anode), int'(expAnode(edgeNo)));
    checkEq(tag, "seg", int'(seg), int'(expSeg(edgeNo)));
  endtask

  task automatic stepAndCheck(input string tag);
    @(posedge clk);
    @(negedge clk);
    checkNow(tag);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: idle pattern straight after reset
  task automatic testReset();
    applyReset();
    checkEq("R1", "anode", int'(anode), 4'b1111);
    checkEq("R1", "seg", int'(seg), 7'b1111111);
  endtask

  // R6: values 0..9, tens slot blank
  task automatic testLowValues();
    for (int i = 0; i < 10 * TICK; i++) begin
      stepAndCheck("R6");
      if (anode == 4'b1101) checkEq("R6", "tens blank", int'(seg), 7'b1111111);
    end
  endtask

  // R4: values 10..19 step at the stated interval
  task automatic testHighValues();
    for (int i = 0; i < 10 * TICK; i++) stepAndCheck("R4");
  endtask

  // R5: 19 rolls to 00
  task automatic testWrap();
    bit sawZero = 1'b0;
    for (int i = 0; i < 2 * TICK; i++) begin
      stepAndCheck("R5");
      if (edgeNo > 20 * TICK && anode == 4'b1110 && seg == pattern(0)) sawZero = 1'b1;
    end
    checkEq("R5", "units zero after wrap", int'(sawZero), 1);
  endtask

  // R2 and R9: every code on the units digit, never blank there
  task automatic testEncoding();
    bit [9:0] seen = '0;
    for (int i = 0; i < 18 * TICK; i++) begin
      stepAndCheck("R2");
      if (anode == 4'b1110) begin
        checkEq("R9", "units not blank", int'(seg != 7'b1111111), 1);
        for (int d = 0; d < 10; d++) if (seg == pattern(d)) seen[d] = 1'b1;
      end
    end
    checkEq("R2", "all ten codes seen", int'(seen), 10'h3FF);
  endtask

  // R3 and R7: anode alternation pattern and upper anodes idle
  task automatic testRefresh();
    int runLen = 0;
    logic [3:0] last = anode;
    for (int i = 0; i < 8 * REF; i++) begin
      stepAndCheck("R7");
      checkEq("R3", "upper anodes", int'(anode[3:2]), 2'b11);
      runLen = (anode == last) ? runLen + 1 : 1;
      last = anode;
      checkEq("R7", "hold length ok", int'(runLen <= REF), 1);
    end
  endtask

  // R1 and R8: reset mid-count, restart from zero in step
  task automatic testMidReset();
    repeat (7) @(posedge clk);
    applyReset();
    checkEq("R1", "anode after mid reset", int'(anode), 4'b1111);
    checkEq("R1", "seg after mid reset", int'(seg), 7'b1111111);
    for (int i = 0; i < 3 * TICK; i++) begin
      stepAndCheck("R8");
      checkEq("R8", "never idle", int'(anode != 4'b1111), 1);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testLowValues();
    testHighValues();
    testWrap();
    testEncoding();
    testRefresh();
    testMidReset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule